// File: doc/BRIEF.md
# Conditional Branch Resolution Unit

This block settles one conditional relative jump per request. A request carries the opcode bytes, a displacement field, the address of the instruction that follows the jump, five status flags (carry, overflow, parity, sign, zero), the count register, the operand-size and address-size attributes, and the current code-segment base and limit. The unit works out whether the condition holds, forms the branch target, and checks that target against the segment bounds.

It is meant to sit at the end of an execute stage. Each request strobe produces, one clock later, a single-cycle result strobe together with the taken decision, a segment fault indication, an unsupported-opcode indication and the instruction pointer to continue from. The status flags are only read, never written back. Between results the outputs keep their last values.

Top module: `cond_branch_unit`

## Requirements
- R1: Short form: when `op_byte0` is 70h through 7Fh, the jump uses `disp[7:0]` as a signed 8-bit displacement, and `op_byte1` is ignored.
- R2: Near form: when `op_byte0` is 0Fh and `op_byte1` is 80h through 8Fh, the displacement is all of `disp` with a 32-bit operand size, and only the signed `disp[15:0]` with a 16-bit operand size.
- R3: The low nibble of the condition opcode picks the test: 0 OF, 1 !OF, 2 CF, 3 !CF, 4 ZF, 5 !ZF, 6 CF|ZF, 7 !CF&!ZF, 8 SF, 9 !SF, A PF, B !PF, C SF!=OF, D SF==OF, E ZF|(SF!=OF), F !ZF&(SF==OF).
- R4: Opcode E3h uses `disp[7:0]` as a signed displacement, ignores all flags, and jumps when the counter is zero. The test covers `count_reg[15:0]` when `addr32` is 0 and all 32 bits when `addr32` is 1.
- R5: A taken jump produces `res_ip` = `next_ip` + the sign-extended displacement, modulo 2^32.
- R6: With `op32` = 0, bits 31:16 of a taken target are zero and no segment fault is raised.
- R7: With `op32` = 1 and the condition true, a target below `seg_base` or above `seg_limit` (unsigned) sets `res_fault`, clears `res_taken`, and returns `next_ip` on `res_ip`. A false condition never faults.
- R8: When the condition is false, `res_taken` is 0 and `res_ip` equals `next_ip`.
- R9: Any other opcode combination sets `res_invalid`, leaves `res_taken` and `res_fault` at 0, and returns `next_ip` on `res_ip`.
- R10: Results appear on the clock edge after `req_valid`. `res_valid` is high for exactly that one cycle, and the other outputs hold their values until the next result.
- R11: A synchronous active-low reset clears every output to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| req_valid | input | 1 | Request strobe |
| op_byte0 | input | 8 | First opcode byte |
| op_byte1 | input | 8 | Second opcode byte (near form only) |
| disp | input | 32 | Displacement field, low bits used as the form dictates |
| next_ip | input | 32 | Address of the instruction after the jump |
| flag_cf | input | 1 | Carry flag |
| flag_of | input | 1 | Overflow flag |
| flag_pf | input | 1 | Parity flag |
| flag_sf | input | 1 | Sign flag |
| flag_zf | input | 1 | Zero flag |
| count_reg | input | 32 | Counter register for the counter-zero jump |
| op32 | input | 1 | 1: 32-bit operand size, 0: 16-bit |
| addr32 | input | 1 | 1: 32-bit address size, 0: 16-bit |
| seg_base | input | 32 | Lowest legal code address |
| seg_limit | input | 32 | Highest legal code address |
| res_valid | output | 1 | One-cycle result strobe |
| res_taken | output | 1 | Jump taken |
| res_fault | output | 1 | Target outside the code segment |
| res_invalid | output | 1 | Opcode not a supported conditional jump |
| res_ip | output | 32 | Instruction pointer to continue from |

## Verification
The assertions assume that request inputs are stable and defined in the cycle `req_valid` is high, and that `seg_base` is not above `seg_limit` whenever a fault is expected. They also assume the timing relation only after reset is released, so they are disabled while `rst_n` is low. The stimulus changes inputs only on the falling edge, keeps every segment window ordered, and separates requests with idle cycles so that the hold behaviour and the strobe width can both be observed.

// File: rtl/cbr_pkg.sv
// Package: shared types for the conditional branch resolution unit.
// Assumes opcode bytes are 8 bits wide; pointer width is set per module.
package cbr_pkg;

    // Instruction form recognised by the decoder
    typedef enum logic [1:0] {
        FORM_SHORT = 2'd0,
        FORM_NEAR  = 2'd1,
        FORM_CTRZ  = 2'd2,
        FORM_BAD   = 2'd3
    } jform_t;

    // Status flags consumed by the condition evaluator
    typedef struct packed {
        logic cf;
        logic of;
        logic pf;
        logic sf;
        logic zf;
    } flags_t;

    localparam logic [7:0] OPC_SHORT_HI = 8'h7;
    localparam logic [7:0] OPC_ESCAPE   = 8'h0F;
    localparam logic [3:0] OPC_NEAR_HI  = 4'h8;
    localparam logic [7:0] OPC_CTRZ     = 8'hE3;

endpackage

// File: rtl/cbr_decode.sv
// Module: cbr_decode
// Classifies the opcode bytes into an instruction form, extracts the
// condition nibble, and sign-extends the displacement to the pointer width.
// Assumes XLEN is at least 16.
module cbr_decode
    import cbr_pkg::*;
#(
    parameter int XLEN = 32
) (
    input  logic [7:0]      op_byte0,
    input  logic [7:0]      op_byte1,
    input  logic [XLEN-1:0] disp,
    input  logic            op32,
    output jform_t          form,
    output logic [3:0]      cond_nib,
    output logic [XLEN-1:0] disp_ext
);
    localparam int HALF = XLEN / 2;

    logic [XLEN-1:0] ext8;
    logic [XLEN-1:0] ext16;

    // Sign-extend the two shorter displacement widths
    always_comb begin
        ext8  = {{(XLEN-8){disp[7]}}, disp[7:0]};
        ext16 = {{(XLEN-HALF){disp[HALF-1]}}, disp[HALF-1:0]};
    end

    // Decide the form and choose the matching displacement
    always_comb begin
        form     = FORM_BAD;
        cond_nib = 4'h0;
        disp_ext = ext8;
        if (op_byte0[7:4] == OPC_SHORT_HI[3:0]) begin
            form     = FORM_SHORT;
            cond_nib = op_byte0[3:0];
            disp_ext = ext8;
        end else if (op_byte0 == OPC_ESCAPE && op_byte1[7:4] == OPC_NEAR_HI) begin
            form     = FORM_NEAR;
            cond_nib = op_byte1[3:0];
            disp_ext = op32 ? disp : ext16;
        end else if (op_byte0 == OPC_CTRZ) begin
            form     = FORM_CTRZ;
            disp_ext = ext8;
        end
    end
endmodule

// File: rtl/cbr_cond_eval.sv
// Module: cbr_cond_eval
// Evaluates the branch condition: a flag test chosen by the condition
// nibble, or a zero test of the counter for the counter form.
// Assumes form has already been decoded; returns 0 for FORM_BAD.
module cbr_cond_eval
    import cbr_pkg::*;
#(
    parameter int XLEN = 32
) (
    input  jform_t          form,
    input  logic [3:0]      cond_nib,
    input  flags_t          flags,
    input  logic [XLEN-1:0] count_reg,
    input  logic            addr32,
    output logic            cond_true
);
    localparam int HALF = XLEN / 2;

    logic base_test;
    logic sign_ne_ovf;
    logic ctr_zero;

    // Counter zero test at the width chosen by the address size
    always_comb begin
        ctr_zero = addr32 ? (count_reg == '0) : (count_reg[HALF-1:0] == '0);
    end

    // Flag test on nibble bits 3:1; bit 0 inverts the sense
    always_comb begin
        sign_ne_ovf = flags.sf ^ flags.of;
        unique case (cond_nib[3:1])
            3'd0: base_test = flags.of;
            3'd1: base_test = flags.cf;
            3'd2: base_test = flags.zf;
            3'd3: base_test = flags.cf | flags.zf;
            3'd4: base_test = flags.sf;
            3'd5: base_test = flags.pf;
            3'd6: base_test = sign_ne_ovf;
            default: base_test = flags.zf | sign_ne_ovf;
        endcase
    end

    // Merge the flag test and the counter test according to the form
    always_comb begin
        unique case (form)
            FORM_SHORT, FORM_NEAR: cond_true = base_test ^ cond_nib[0];
            FORM_CTRZ:             cond_true = ctr_zero;
            default:               cond_true = 1'b0;
        endcase
    end
endmodule

// File: rtl/cbr_target.sv
// Module: cbr_target
// Adds the displacement to the next-sequential pointer, truncates the sum
// for a 16-bit operand size, and flags a sum outside [seg_base, seg_limit]
// for a 32-bit operand size. Assumes seg_base <= seg_limit.
module cbr_target #(
    parameter int XLEN = 32
) (
    input  logic [XLEN-1:0] next_ip,
    input  logic [XLEN-1:0] disp_ext,
    input  logic            op32,
    input  logic [XLEN-1:0] seg_base,
    input  logic [XLEN-1:0] seg_limit,
    output logic [XLEN-1:0] target,
    output logic            out_of_seg
);
    localparam int HALF = XLEN / 2;

    logic [XLEN-1:0] sum;

    // Raw sum, wrapping at the pointer width
    always_comb begin
        sum = next_ip + disp_ext;
    end

    // Truncate for small operand size, else check against the segment
    always_comb begin
        if (op32) begin
            target     = sum;
            out_of_seg = (sum < seg_base) || (sum > seg_limit);
        end else begin
            target     = {{(XLEN-HALF){1'b0}}, sum[HALF-1:0]};
            out_of_seg = 1'b0;
        end
    end
endmodule

// File: rtl/cond_branch_unit.sv
// Module: cond_branch_unit (top)
// Resolves one conditional relative jump per req_valid and registers the
// outcome, presenting it with a one-cycle res_valid strobe.
// Assumes request inputs are stable in the cycle req_valid is high.
module cond_branch_unit
    import cbr_pkg::*;
#(
    parameter int XLEN = 32
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            req_valid,
    input  logic [7:0]      op_byte0,
    input  logic [7:0]      op_byte1,
    input  logic [XLEN-1:0] disp,
    input  logic [XLEN-1:0] next_ip,
    input  logic            flag_cf,
    input  logic            flag_of,
    input  logic            flag_pf,
    input  logic            flag_sf,
    input  logic            flag_zf,
    input  logic [XLEN-1:0] count_reg,
    input  logic            op32,
    input  logic            addr32,
    input  logic [XLEN-1:0] seg_base,
    input  logic [XLEN-1:0] seg_limit,
    output logic            res_valid,
    output logic            res_taken,
    output logic            res_fault,
    output logic            res_invalid,
    output logic [XLEN-1:0] res_ip
);
    localparam int HALF = XLEN / 2;

    jform_t          form;
    logic [3:0]      cond_nib;
    logic [XLEN-1:0] disp_ext;
    logic            cond_true;
    logic [XLEN-1:0] target;
    logic            out_of_seg;
    flags_t          flags;
    logic            take_c;
    logic            fault_c;
    logic [XLEN-1:0] ip_c;

    // Gather the flags into the shared struct
    always_comb begin
        flags = '{cf: flag_cf, of: flag_of, pf: flag_pf, sf: flag_sf, zf: flag_zf};
    end

    cbr_decode #(.XLEN(XLEN)) u_dec (
        .op_byte0 (op_byte0),
        .op_byte1 (op_byte1),
        .disp     (disp),
        .op32     (op32),
        .form     (form),
        .cond_nib (cond_nib),
        .disp_ext (disp_ext)
    );

    cbr_cond_eval #(.XLEN(XLEN)) u_cond (
        .form      (form),
        .cond_nib  (cond_nib),
        .flags     (flags),
        .count_reg (count_reg),
        .addr32    (addr32),
        .cond_true (cond_true)
    );

    cbr_target #(.XLEN(XLEN)) u_tgt (
        .next_ip    (next_ip),
        .disp_ext   (disp_ext),
        .op32       (op32),
        .seg_base   (seg_base),
        .seg_limit  (seg_limit),
        .target     (target),
        .out_of_seg (out_of_seg)
    );

    // Final decision: a fault suppresses the jump and keeps the old pointer
    always_comb begin
        fault_c = cond_true && out_of_seg;
        take_c  = cond_true && !out_of_seg;
        ip_c    = take_c ? target : next_ip;
    end

    // Result register: strobe every cycle, payload only on a request
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            res_valid   <= 1'b0;
            res_taken   <= 1'b0;
            res_fault   <= 1'b0;
            res_invalid <= 1'b0;
            res_ip      <= '0;
        end else begin
            res_valid <= req_valid;
            if (req_valid) begin
                res_taken   <= take_c;
                res_fault   <= fault_c;
                res_invalid <= (form == FORM_BAD);
                res_ip      <= ip_c;
            end
        end
    end

    // R10: the strobe follows a request by exactly one cycle
    assert_strobe_follows_req_R10: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> res_valid);
    assert_strobe_single_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> !res_valid);
    // R7: a fault never coexists with a taken jump
    assert_fault_excludes_taken_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !(res_taken && res_fault));
    // R9: an unsupported opcode neither jumps nor faults
    assert_invalid_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
        res_invalid |-> (!res_taken && !res_fault));
    // R8: any result that is not a taken jump returns the sequential pointer
    assert_fallthrough_ip_R8: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> (res_taken || res_ip == $past(next_ip)));
    // R6: small operand size clears the upper pointer half and never faults
    assert_trunc_upper_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !op32) |=> (!res_fault && (!res_taken || res_ip[XLEN-1:HALF] == '0)));
    // R11: while reset is applied the outputs are cleared on the next edge
    assert_reset_clears_R11: assert property (@(posedge clk)
        !rst_n |=> (!res_valid && !res_taken && !res_fault && !res_invalid && res_ip == '0));
endmodule

// File: tb/sim_cond_branch_unit.sv
module sim_cond_branch_unit;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic [7:0]  op_byte0 = 8'h00;
    logic [7:0]  op_byte1 = 8'h00;
    logic [31:0] disp = '0;
    logic [31:0] next_ip = '0;
    logic        flag_cf = 0, flag_of = 0, flag_pf = 0, flag_sf = 0, flag_zf = 0;
    logic [31:0] count_reg = '0;
    logic        op32 = 1'b1;
    logic        addr32 = 1'b1;
    logic [31:0] seg_base = '0;
    logic [31:0] seg_limit = 32'hFFFF_FFFF;
    logic        res_valid, res_taken, res_fault, res_invalid;
    logic [31:0] res_ip;

    int n_checks = 0;
    int n_fail = 0;

    always #10 clk = ~clk;   // 50 MHz

    cond_branch_unit u0 (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid),
        .op_byte0(op_byte0), .op_byte1(op_byte1), .disp(disp), .next_ip(next_ip),
        .flag_cf(flag_cf), .flag_of(flag_of), .flag_pf(flag_pf), .flag_sf(flag_sf),
        .flag_zf(flag_zf), .count_reg(count_reg), .op32(op32), .addr32(addr32),
        .seg_base(seg_base), .seg_limit(seg_limit),
        .res_valid(res_valid), .res_taken(res_taken), .res_fault(res_fault),
        .res_invalid(res_invalid), .res_ip(res_ip)
    );

    // Condition table straight from R3, flags packed {cf,of,pf,sf,zf}
    function automatic logic want_cond(input logic [3:0] n, input logic [4:0] f);
        logic c, o, p, s, z;
        {c, o, p, s, z} = f;
        case (n)
            4'h0: return o;          4'h1: return !o;
            4'h2: return c;          4'h3: return !c;
            4'h4: return z;          4'h5: return !z;
            4'h6: return c || z;     4'h7: return !c && !z;
            4'h8: return s;          4'h9: return !s;
            4'hA: return p;          4'hB: return !p;
            4'hC: return s != o;     4'hD: return s == o;
            4'hE: return z || (s != o);
            default: return !z && (s == o);
        endcase
    endfunction

    logic        e_taken, e_fault, e_inv;
    logic [31:0] e_ip;

    // Expected outcome per R1..R9 from the currently driven inputs
    task automatic predict();
        logic        is_cond, is_ctr, cond;
        logic [31:0] d, t;
        logic [4:0]  f;
        f = {flag_cf, flag_of, flag_pf, flag_sf, flag_zf};
        is_cond = 0; is_ctr = 0; cond = 0;
        d = {{24{disp[7]}}, disp[7:0]};
        if (op_byte0 >= 8'h70 && op_byte0 <= 8'h7F) begin
            is_cond = 1; cond = want_cond(op_byte0[3:0], f);
        end else if (op_byte0 == 8'h0F && op_byte1 >= 8'h80 && op_byte1 <= 8'h8F) begin
            is_cond = 1; cond = want_cond(op_byte1[3:0], f);
            d = op32 ? disp : {{16{disp[15]}}, disp[15:0]};
        end else if (op_byte0 == 8'hE3) begin
            is_ctr = 1;
            cond = addr32 ? (count_reg == 0) : (count_reg[15:0] == 0);
        end
        e_inv = !(is_cond || is_ctr);
        t = next_ip + d;
        if (!op32) t = t & 32'h0000_FFFF;
        e_fault = cond && op32 && (t < seg_base || t > seg_limit);
        e_taken = cond && !e_fault;
        e_ip = e_taken ? t : next_ip;
    endtask

    task automatic check(input string tag, input logic ok, input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // Issue one request, then compare the result one clock later
    task automatic run_req(input string tag);
        predict();
        req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        check(tag, res_valid && res_taken == e_taken && res_fault == e_fault &&
                   res_invalid == e_inv && res_ip == e_ip,
              {res_valid, res_taken, res_fault, res_invalid, 28'h0, res_ip},
              {1'b1, e_taken, e_fault, e_inv, 28'h0, e_ip});
    endtask

    task automatic set_flags(input logic [4:0] f);
        {flag_cf, flag_of, flag_pf, flag_sf, flag_zf} = f;
    endtask

    initial begin
        #4_000_000;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
        $finish;
    end

    initial begin
        logic [31:0] held;
        // R11: reset clears outputs even with a request pending
        req_valid = 1'b1; op_byte0 = 8'h74; flag_zf = 1;
        repeat (3) @(negedge clk);
        check("R11 reset", {res_valid, res_taken, res_fault, res_invalid} == 0 && res_ip == 0,
              {28'h0, res_valid, res_taken, res_fault, res_invalid, res_ip}, 64'h0);
        req_valid = 1'b0; rst_n = 1'b1;
        @(negedge clk);

        // R3 and R1: every condition nibble against every flag pattern, short form
        for (int n = 0; n < 16; n++) begin
            for (int f = 0; f < 32; f++) begin
                op_byte0 = 8'h70 | 8'(n); op_byte1 = 8'(f * 9);
                disp = {24'hABCDEF, 8'(n * 23 + f * 5)};
                next_ip = 32'h4000_0000 + 32'(f * 3);
                set_flags(5'(f));
                run_req("R3 R1 short");
            end
        end

        // R2 and R5: near form, both operand sizes, several displacements
        for (int n = 0; n < 16; n++) begin
            for (int k = 0; k < 4; k++) begin
                for (int w = 0; w < 2; w++) begin
                    op_byte0 = 8'h0F; op_byte1 = 8'h80 | 8'(n);
                    op32 = w[0];
                    case (k)
                        0: disp = 32'h0000_7FFF;
                        1: disp = 32'h1234_8000;
                        2: disp = 32'h8000_0010;
                        default: disp = 32'hFFFF_FF00;
                    endcase
                    next_ip = 32'h0000_9000 + 32'(n);
                    set_flags(5'(n * 7 + k));
                    run_req("R2 R5 near");
                end
            end
        end
        op32 = 1'b1;

        // R6: truncation at 16-bit operand size, with a window that would fault
        op_byte0 = 8'h74; flag_zf = 1; op32 = 0;
        next_ip = 32'h1234_FFF0; disp = 32'h20;
        seg_base = 32'hFFFF_0000; seg_limit = 32'hFFFF_FFFF;
        run_req("R6 trunc");
        check("R6 value", res_ip == 32'h0000_0010, {32'h0, res_ip}, 64'h10);
        op32 = 1;

        // R7: segment window edges, taken and not taken
        seg_base = 32'h1000; seg_limit = 32'h1FFF; next_ip = 32'h1800;
        for (int k = 0; k < 4; k++) begin
            for (int z = 0; z < 2; z++) begin
                op_byte0 = 8'h0F; op_byte1 = 8'h84; flag_zf = z[0];
                case (k)
                    0: disp = 32'hFFFF_F7FF;   // 0x0FFF
                    1: disp = 32'hFFFF_F800;   // 0x1000
                    2: disp = 32'h0000_07FF;   // 0x1FFF
                    default: disp = 32'h0000_0800; // 0x2000
                endcase
                run_req("R7 limit");
            end
        end
        seg_base = 0; seg_limit = 32'hFFFF_FFFF;

        // R8: condition false keeps the sequential pointer
        op_byte0 = 8'h75; flag_zf = 1; next_ip = 32'hCAFE_0000; disp = 32'h7F;
        run_req("R8 fallthrough");

        // R4: counter form over counts, address sizes and flag patterns
        for (int c = 0; c < 5; c++) begin
            for (int a = 0; a < 2; a++) begin
                for (int f = 0; f < 2; f++) begin
                    op_byte0 = 8'hE3; addr32 = a[0];
                    case (c)
                        0: count_reg = 32'h0;
                        1: count_reg = 32'h0001_0000;
                        2: count_reg = 32'h1;
                        3: count_reg = 32'hFFFF_0000;
                        default: count_reg = 32'h0000_8000;
                    endcase
                    set_flags(f[0] ? 5'h1F : 5'h00);
                    disp = 32'h80; next_ip = 32'h0000_5000;
                    run_req("R4 counter");
                end
            end
        end
        addr32 = 1;

        // R9: sweep of first and second opcode bytes
        set_flags(5'h1F); count_reg = 0; next_ip = 32'h2222_0000; disp = 32'h10;
        for (int b = 0; b < 256; b++) begin
            op_byte0 = 8'(b); op_byte1 = 8'h84;
            run_req("R9 byte0");
        end
        for (int b = 0; b < 256; b++) begin
            op_byte0 = 8'h0F; op_byte1 = 8'(b);
            run_req("R9 byte1");
        end

        // R10: idle cycle drops the strobe and holds the payload
        op_byte0 = 8'h7A; flag_pf = 1; disp = 32'h04; next_ip = 32'h100;
        run_req("R10 result");
        held = res_ip;
        op_byte0 = 8'h00; next_ip = 32'h999;
        @(negedge clk);
        check("R10 hold", !res_valid && res_taken && res_ip == held,
              {31'h0, res_valid, res_ip}, {32'h0, held});

        // R11: reset mid-run clears a held result
        rst_n = 0;
        @(negedge clk);
        check("R11 midrun", !res_taken && res_ip == 0, {32'h0, res_ip}, 64'h0);
        rst_n = 1;
        @(negedge clk);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
        $finish;
    end
endmodule